// File: doc/BRIEF.md
# Prescaled 8-bit PWM Generator

This block drives one pulse-width-modulated output from a single 32-bit control word. Software writes the word through a synchronous write strobe and reads it back on a read data bus. The word holds a run bit, a level to drive while stopped, an 8-bit clock-divider setting and an 8-bit duty setting. While running, the input clock is divided down to a step tick. Each output frame spans 256 ticks. The output is low for the first `duty` ticks of the frame and high for the rest.

Divider and duty changes are staged. The running frame keeps the values it started with. New values are taken only when the next frame begins, so a single frame never mixes old and new settings. Starting the generator clears the divider and the frame position. Stopping it puts the stopped level on the pin one clock later.

Top module: `pwm_prescaled`

## Requirements
- R1: After reset, the register reads as all zeros and `pwm_out` is low.
- R2: While the generator is stopped (`pwm_out` not running), `pwm_out` equals bit 30 of the register and follows every write to that bit.
- R3: A write stores bit 31 (run), bit 30 (stopped level), bits 15:8 (divider) and bits 7:0 (duty). `rd_data` returns these values starting the cycle after the write strobe.
- R4: Bits 29:16 always read as zero, and any value written to them is dropped.
- R5: One clock after the run bit goes from 0 to 1, the divider and frame position start again from zero. The output then begins a fresh frame with its low part.
- R6: A frame lasts 256 ticks, and one tick lasts N clocks, where N is the divider field. The output is low for the first `duty` ticks of the frame and high for the remaining `256 - duty` ticks.
- R7: A divider field of 0 gives N = 256, so one frame lasts 65536 clocks.
- R8: Divider and duty values are taken only at a frame start. A write that reaches the register on the same clock edge as a frame start takes effect at the frame after that one.
- R9: While running, bit 30 has no effect on `pwm_out`.
- R10: One clock after the run bit reads 0, `pwm_out` shows the stopped level.
- R11: With duty 255 and N = 1, the output is low for 255 clocks and high for exactly one clock per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to be written |
| rd_data | output | 32 | Current control word |
| pwm_out | output | 1 | Modulated output |

## Verification
Two events can land on the same clock edge: a software write reaching the register, and the frame boundary that copies the register into the active settings. The bench provokes this twice. In the first case the write lands one edge before a boundary, and the next frame must already use the new duty. In the second case the write lands exactly on the boundary edge, and the next frame must still use the old duty. The output level is judged a few clocks past the old and the new duty point, where the two outcomes give different levels.

// File: rtl/pwm_pkg.sv
// Package: shared widths and the decoded control-word type for the PWM block.
// Assumes: a single channel and a fixed 8-bit step width.
package pwm_pkg;
    localparam int STEP_W = 8;

    typedef struct packed {
        logic              run;
        logic              stop_lvl;
        logic [STEP_W-1:0] div;
        logic [STEP_W-1:0] duty;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_cfg_reg.sv
// Control word storage. It captures the run bit, the stopped level, the divider
// and the duty fields on a write strobe, and presents the word for readback.
// Assumes: REG_W >= 2*W + 2. The bits between the duty/divider fields and the
// two top bits are not stored.
module pwm_cfg_reg
    import pwm_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int W     = STEP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output pwm_cfg_t         cfg,
    output logic [REG_W-1:0] rd_data
);
    localparam int RUN_BIT  = REG_W - 1;
    localparam int LVL_BIT  = REG_W - 2;
    localparam int DIV_LSB  = W;
    localparam int DUTY_LSB = 0;

    logic unused_gap;
    assign unused_gap = ^wr_data[LVL_BIT-1:2*W];

    // Capture the stored fields on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.run      <= wr_data[RUN_BIT];
            cfg.stop_lvl <= wr_data[LVL_BIT];
            cfg.div      <= wr_data[DIV_LSB +: W];
            cfg.duty     <= wr_data[DUTY_LSB +: W];
        end
    end

    // Reassemble the readback word. The gap bits read as zero.
    always_comb begin
        rd_data                 = '0;
        rd_data[RUN_BIT]        = cfg.run;
        rd_data[LVL_BIT]        = cfg.stop_lvl;
        rd_data[DIV_LSB +: W]   = cfg.div;
        rd_data[DUTY_LSB +: W]  = cfg.duty;
    end
endmodule

// File: rtl/pwm_tick_div.sv
// Clock divider. It issues one tick every N clocks while running, where N is the
// active divider value and 0 stands for 2**W. It is held at zero while stopped.
// Assumes: div_act changes only on the clock where a tick wraps the count, or
// while stopped.
module pwm_tick_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div_act,
    output logic         tick,
    output logic [W-1:0] cnt
);
    logic [W-1:0] last;

    // The terminal count is N-1. Value 0 wraps to all ones, which gives 2**W.
    assign last = div_act - W'(1);
    assign tick = run && (cnt == last);

    // Count clocks inside one tick. Clear while stopped and on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= last));
endmodule

// File: rtl/pwm_frame.sv
// Frame sequencer. It holds the active divider and duty values, steps the frame
// position on each tick, and compares the position with the duty value.
// Assumes: the tick comes from pwm_tick_div. The active values load while
// stopped and at each frame wrap.
module pwm_frame #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] new_div,
    input  logic [W-1:0] new_duty,
    output logic [W-1:0] div_act,
    output logic [W-1:0] duty_act,
    output logic [W-1:0] pos,
    output logic         level_hi
);
    logic frame_end;

    assign frame_end = tick && (pos == '1);
    assign level_hi  = (pos >= duty_act);

    // Load the staged settings while stopped or at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_act  <= '0;
            duty_act <= '0;
        end else if (!run || frame_end) begin
            div_act  <= new_div;
            duty_act <= new_duty;
        end
    end

    // Step the frame position once per tick. Hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos <= '0;
        end else if (tick) begin
            pos <= pos + W'(1);
        end
    end

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_end) |=> ($stable(duty_act) && $stable(div_act)));

    p_frame_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && frame_end) |=> (pos == '0));
endmodule

// File: rtl/pwm_prescaled.sv
// Top of the single-channel PWM generator: the control word, the divider and
// the frame sequencer. The generator runs one clock after the run bit is stored.
// Assumes: software keeps the duty value within 1..255.
module pwm_prescaled
    import pwm_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int W     = STEP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             pwm_out
);
    pwm_cfg_t     cfg;
    logic         run;
    logic         tick;
    logic [W-1:0] div_cnt;
    logic [W-1:0] div_act;
    logic [W-1:0] duty_act;
    logic [W-1:0] frame_pos;
    logic         level_hi;

    pwm_cfg_reg #(.REG_W(REG_W), .W(W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    // Delay the run bit by one clock. Counters clear while this is low.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= cfg.run;
    end

    pwm_tick_div #(.W(W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_act (div_act),
        .tick    (tick),
        .cnt     (div_cnt)
    );

    pwm_frame #(.W(W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .new_div  (cfg.div),
        .new_duty (cfg.duty),
        .div_act  (div_act),
        .duty_act (duty_act),
        .pos      (frame_pos),
        .level_hi (level_hi)
    );

    // Select between the modulated level and the stopped level.
    assign pwm_out = run ? level_hi : cfg.stop_lvl;

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (div_cnt == '0 && frame_pos == '0));

    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg.run) |=> !run);
endmodule

// File: tb/pwm_prescaled_test.sv
module pwm_prescaled_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int          c;
        bit          is_rd;
        logic [31:0] v;
        string       tag;
    } exp_t;

    exp_t q[$];

    pwm_prescaled uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk(bit en, bit lvl, logic [7:0] dv, logic [7:0] dt);
        return {en, lvl, 14'b0, dv, dt};
    endfunction

    task automatic push(int c, bit rd, logic [31:0] v, string tag);
        exp_t e;
        e.c = c; e.is_rd = rd; e.v = v; e.tag = tag;
        q.push_back(e);
    endtask

    // Drive a write so that it lands on edge number e. Called at a falling edge.
    task automatic wr_at(int e, logic [31:0] v);
        while (cyc < e - 1) @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    // Monitor: pop the expected items that are due and compare them away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].c <= cyc) begin
                exp_t e;
                logic [31:0] act;
                e = q.pop_front();
                act = e.is_rd ? rd_data : {31'b0, pwm_out};
                n_cmp++;
                if (e.c < cyc) begin
                    n_bad++;
                    $display("FAIL %s: item for cycle %0d missed at cycle %0d", e.tag, e.c, cyc);
                end else if (act !== e.v) begin
                    n_bad++;
                    $display("FAIL %s: cycle %0d %s actual %h expected %h", e.tag, cyc,
                             e.is_rd ? "rd_data" : "pwm_out", act, e.v);
                end
            end
        end
    end

    // Watchdog
    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int w, s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        push(cyc + 1, 1'b0, 32'd0, "R1");
        push(cyc + 1, 1'b1, 32'd0, "R1");
        drain();

        // R2 and R4: stopped level, and junk in the gap bits dropped
        w = cyc + 2;
        push(w, 1'b1, mk(0, 1, 8'h11, 8'h22), "R4");
        push(w, 1'b0, 32'd1, "R2");
        push(w + 5, 1'b0, 32'd1, "R2");
        wr_at(w, mk(0, 1, 8'h11, 8'h22) | 32'h3FFF_0000);
        drain();

        // Main run: N=2, duty 64, then staged updates and the same-edge corner case
        w = cyc + 2;
        s = w + 1;
        push(w, 1'b1, mk(1, 0, 8'd2, 8'd64), "R3");
        push(w, 1'b0, 32'd0, "R2");
        push(s, 1'b0, 32'd0, "R5");
        push(s + 11, 1'b0, 32'd0, "R9");
        push(s + 127, 1'b0, 32'd0, "R6");
        push(s + 128, 1'b0, 32'd1, "R6");
        push(s + 511, 1'b0, 32'd1, "R6");
        push(s + 512, 1'b0, 32'd0, "R6");
        push(s + 600, 1'b1, mk(1, 1, 8'd1, 8'd192), "R3");
        push(s + 639, 1'b0, 32'd0, "R8");
        push(s + 640, 1'b0, 32'd1, "R8");
        push(s + 1023, 1'b0, 32'd1, "R8");
        push(s + 1024, 1'b0, 32'd0, "R8");
        push(s + 1215, 1'b0, 32'd0, "R8");
        push(s + 1216, 1'b0, 32'd1, "R8");
        push(s + 1279, 1'b0, 32'd1, "R8");
        push(s + 1280, 1'b0, 32'd0, "R8");
        push(s + 1567, 1'b0, 32'd0, "R8");
        push(s + 1568, 1'b0, 32'd1, "R8");
        push(s + 1823, 1'b0, 32'd0, "R8");
        push(s + 1824, 1'b0, 32'd1, "R8");
        push(s + 2147, 1'b0, 32'd0, "R8");
        push(s + 2148, 1'b0, 32'd1, "R8");
        push(s + 2200, 1'b0, 32'd1, "R10");
        push(s + 2201, 1'b0, 32'd0, "R10");
        wr_at(w, mk(1, 0, 8'd2, 8'd64));
        wr_at(s + 10, mk(1, 1, 8'd2, 8'd64));
        wr_at(s + 600, mk(1, 1, 8'd1, 8'd192));
        wr_at(s + 1535, mk(1, 1, 8'd1, 8'd32));
        wr_at(s + 1792, mk(1, 1, 8'd1, 8'd100));
        wr_at(s + 2200, mk(0, 0, 8'd1, 8'd100));
        drain();

        // R11 with R5: restart, N=1, duty 255
        w = cyc + 2;
        s = w + 1;
        push(s, 1'b0, 32'd0, "R5");
        push(s + 254, 1'b0, 32'd0, "R11");
        push(s + 255, 1'b0, 32'd1, "R11");
        push(s + 256, 1'b0, 32'd0, "R11");
        wr_at(w, mk(1, 0, 8'd1, 8'd255));
        wr_at(s + 300, mk(0, 0, 8'd1, 8'd255));
        drain();

        // R7: divider field 0 means 256
        w = cyc + 2;
        s = w + 1;
        push(w, 1'b1, mk(1, 0, 8'd0, 8'd1), "R3");
        push(s, 1'b0, 32'd0, "R7");
        push(s + 255, 1'b0, 32'd0, "R7");
        push(s + 256, 1'b0, 32'd1, "R7");
        push(s + 65535, 1'b0, 32'd1, "R7");
        push(s + 65536, 1'b0, 32'd0, "R7");
        wr_at(w, mk(1, 0, 8'd0, 8'd1));
        drain();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule